// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a serial bit stream, one bit per clock when a valid strobe is high. It signals whenever the four most recently accepted bits, oldest first, read 1, 1, 0, 1. Matches may share bits, so the final 1 of one match can be the first 1 of the next.

Two independent detectors run in parallel on the same stream and drive separate outputs. One is a state-decoded (Moore) machine with five states. Its flag is registered behaviour and appears in the cycle after the clock edge that accepts the completing bit. The other is an input-decoded (Mealy) machine with four states. Its flag is combinational from the state and the bit currently presented, so it rises one cycle earlier.

A consumer that can take a combinational path uses the early flag. A consumer that needs a glitch-free, state-only signal uses the late one. The asynchronous active-low reset is synchronized inside the block before it reaches the state registers. Both detectors leave reset two clock edges after `rst_n` rises.

Top module: `seq1101_pair`

## Requirements
- R1: While `rst_n` is low, both flags are 0 and both detectors are forced to their start state. Reset assertion is asynchronous.
- R2: `flag_mealy` is 1 in a cycle exactly when `bit_vld` is 1, `bit_in` is 1 (1 means logic one), and the three previously accepted bits, oldest first, were 1, 1, 0. In every other cycle it is 0.
- R3: `flag_moore` becomes 1 in the cycle after the clock edge that accepted a bit completing 1101. It keeps its value until the next accepted bit.
- R4: Matches overlap. The stream 1101101 produces two flags on each output, and a 1 arriving right after a match keeps that match's last 1 as history.
- R5: When `bit_vld` is 0, `bit_in` is ignored. Neither detector's history advances, `flag_mealy` is 0 and `flag_moore` holds its value.
- R6: `flag_moore` in any cycle equals the `flag_mealy` value seen in the cycle of the most recent accepted bit, so the Mealy flag leads by one cycle.
- R7: A reset in the middle of a partial match discards it. After 1, 1, 0 and then a reset, a single accepted 1 does not flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | High when `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| flag_moore | output | 1 | State-decoded match flag, one cycle after the completing bit |
| flag_mealy | output | 1 | Input-decoded match flag, in the cycle of the completing bit |

## Verification
A hand-worked table drives the stream 1101101 with valid gaps inserted. This shows that overlapping matches are kept and that idle cycles neither advance history nor disturb the held late flag.

A mid-match reset shows that partial history is discarded. Several hundred random bits with random valid gaps are compared against a four-bit shift-register model. That comparison separates a wrong transition out of any state from a wrong flag timing. The late flag is also compared with the early flag of the previous accepted cycle, which exposes any loss of the one-cycle lead.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

  // Five-state encoding for the state-decoded detector; the match state
  // is the only one with the top bit set.
  typedef enum logic [2:0] {
    MO_IDLE = 3'b000,
    MO_GOT1 = 3'b001,
    MO_GOT11 = 3'b010,
    MO_GOT110 = 3'b011,
    MO_MATCH = 3'b100
  } moore_st_e;

  // Four-state encoding for the input-decoded detector.
  typedef enum logic [1:0] {
    ME_IDLE = 2'b00,
    ME_GOT1 = 2'b01,
    ME_GOT11 = 2'b10,
    ME_GOT110 = 2'b11
  } mealy_st_e;

  localparam int RST_STAGES = 2;

endpackage

// File: rtl/seq1101_rst_sync.sv
module seq1101_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/seq1101_moore.sv
module seq1101_moore
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic flag
);

  moore_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (bit_vld) begin
      case (st_q)
        MO_IDLE:   st_d = bit_in ? MO_GOT1   : MO_IDLE;
        MO_GOT1:   st_d = bit_in ? MO_GOT11  : MO_IDLE;
        MO_GOT11:  st_d = bit_in ? MO_GOT11  : MO_GOT110;
        MO_GOT110: st_d = bit_in ? MO_MATCH  : MO_IDLE;
        MO_MATCH:  st_d = bit_in ? MO_GOT11  : MO_IDLE;
        default:   st_d = MO_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= MO_IDLE;
    else if (bit_vld) st_q <= st_d;
  end

  assign flag = st_q[2];

  // R5: an idle cycle leaves the history untouched
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(st_q));

  // R3: the late flag is held across idle cycles
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !bit_vld) |=> flag);

  // R4: a 1 after a match keeps two ones of history
  assert_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MO_MATCH && bit_vld && bit_in) |=> (st_q == MO_GOT11));

endmodule

// File: rtl/seq1101_mealy.sv
module seq1101_mealy
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic flag
);

  mealy_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (bit_vld) begin
      case (st_q)
        ME_IDLE:   st_d = bit_in ? ME_GOT1  : ME_IDLE;
        ME_GOT1:   st_d = bit_in ? ME_GOT11 : ME_IDLE;
        ME_GOT11:  st_d = bit_in ? ME_GOT11 : ME_GOT110;
        ME_GOT110: st_d = bit_in ? ME_GOT1  : ME_IDLE;
        default:   st_d = ME_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ME_IDLE;
    else if (bit_vld) st_q <= st_d;
  end

  assign flag = bit_vld && bit_in && (st_q == ME_GOT110);

  // R5: an idle cycle leaves the history untouched
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(st_q));

  // R4: after a hit the last 1 is kept as the start of the next match
  assert_after_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> (st_q == ME_GOT1));

endmodule

// File: rtl/seq1101_pair.sv
module seq1101_pair
  import seq1101_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  output logic flag_moore,
  output logic flag_mealy
);

  logic rst_n_core;

  seq1101_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_core)
  );

  seq1101_moore u_moore (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .flag    (flag_moore)
  );

  seq1101_mealy u_mealy (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .flag    (flag_mealy)
  );

  // R6: an early hit is always followed by the late flag
  assert_lead_R6: assert property (@(posedge clk) disable iff (!rst_n_core)
    flag_mealy |=> flag_moore);

  // R6: the late flag never rises without an early hit one cycle before
  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n_core)
    $rose(flag_moore) |-> $past(flag_mealy));

  // R1: no flag while the core is held in reset
  always_comb begin
    if (!rst_n_core) begin
      assert_reset_quiet_R1: assert (!flag_moore || $isunknown(flag_moore));
    end
  end

endmodule

// File: tb/seq1101_pair_tb.sv
module seq1101_pair_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic flag_moore, flag_mealy;

  int total = 0;
  int bad = 0;

  logic [3:0] hist = '0;
  logic moore_exp = 1'b0;
  logic prev_vld = 1'b0;
  logic prev_mealy = 1'b0;
  int mealy_hits = 0;
  int moore_rises = 0;
  logic moore_last = 1'b0;

  always #2 clk = ~clk;

  seq1101_pair u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .flag_moore (flag_moore),
    .flag_mealy (flag_mealy)
  );

  // {vld, bit, expected flag_mealy, expected flag_moore in the next step}
  localparam int NTBL = 16;
  localparam logic [3:0] TBL [NTBL] = '{
    4'b1100, 4'b1100, 4'b1000, 4'b1111,
    4'b1100, 4'b1000, 4'b1111, 4'b0101,
    4'b0001, 4'b1100, 4'b1000, 4'b0100,
    4'b1111, 4'b1000, 4'b1100, 4'b1000
  };

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag_me,
                      input string tag_mo);
    logic exp_me;
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    #1;
    exp_me = v && ({hist[2:0], b} == 4'b1101);
    check(tag_me, flag_mealy, exp_me);
    check(tag_mo, flag_moore, moore_exp);
    if (prev_vld) check("R6", flag_moore, prev_mealy);
    if (flag_mealy) mealy_hits++;
    if (flag_moore && !moore_last) moore_rises++;
    moore_last = flag_moore;
    if (v) begin
      moore_exp = exp_me;
      hist = {hist[2:0], b};
    end
    prev_vld = v;
    prev_mealy = flag_mealy;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_vld = 1'b1;
    bit_in = 1'b1;
    #1;
    check("R1", flag_moore, 1'b0);
    check("R1", flag_mealy, 1'b0);
    hist = '0;
    moore_exp = 1'b0;
    prev_vld = 1'b0;
    moore_last = 1'b0;
    repeat (2) begin
      @(negedge clk);
      #1;
      check("R1", flag_moore, 1'b0);
      check("R1", flag_mealy, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    bit_vld = 1'b0;
    repeat (3) step(1'b0, 1'b0, "R1", "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // Table walk: hand-worked vectors, stream 1101101 with idle gaps
    begin
      logic pend_mo;
      pend_mo = 1'b0;
      for (int i = 0; i < NTBL; i++) begin
        step(TBL[i][3], TBL[i][2], TBL[i][3] ? "R2" : "R5",
             TBL[i][3] ? "R3" : "R5");
        check("R4", flag_mealy, TBL[i][1]);
        check("R3", flag_moore, pend_mo);
        pend_mo = TBL[i][0];
      end
    end

    // R4: 1101101 gives two hits on each output
    do_reset();
    mealy_hits = 0;
    moore_rises = 0;
    begin
      logic [6:0] ov;
      ov = 7'b1101101;
      for (int i = 6; i >= 0; i--) step(1'b1, ov[i], "R4", "R4");
      step(1'b0, 1'b0, "R5", "R4");
    end
    check("R4", mealy_hits == 2, 1'b1);
    check("R4", moore_rises == 2, 1'b1);

    // R7: reset after a partial 110 discards it
    step(1'b1, 1'b1, "R2", "R3");
    step(1'b1, 1'b1, "R2", "R3");
    step(1'b1, 1'b0, "R2", "R3");
    do_reset();
    step(1'b1, 1'b1, "R7", "R7");
    check("R7", flag_mealy, 1'b0);
    step(1'b0, 1'b0, "R5", "R7");
    check("R7", flag_moore, 1'b0);

    // R5: ignored bits during a held match
    step(1'b1, 1'b1, "R2", "R3");
    step(1'b1, 1'b0, "R2", "R3");
    step(1'b1, 1'b1, "R2", "R3");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0], "R5", "R5");
      check("R5", flag_moore, 1'b1);
    end

    // Random streams with random idle gaps
    for (int i = 0; i < 400; i++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = ($urandom % 3) != 0;
      step(v, b, v ? "R2" : "R5", "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule